// File: doc/BRIEF.md
# Transposed Four-Tap Low-Pass FIR Filter

This block is a clocked finite impulse response filter with four taps. It takes one unsigned sample per clock on `x` and presents `y`, the weighted sum of the newest captured sample and the three captured before it. The four weights are constant parameters. Their defaults are 3, 6, 7 and 9, applied to the newest through the oldest sample.

The datapath is in transposed form. The incoming sample is captured once. That captured sample then feeds four constant multipliers in parallel, each built from shifts and adds. A chain of three partial-sum registers carries the older contributions towards the output. The final adder, which combines the newest product with the nearest partial sum, drives `y` directly. Each partial-sum register is only as wide as the worst case it can hold. The output width covers the largest possible sum of four maximum products, so no stage can overflow.

Top module: `fir4_transposed`

## Requirements
- R1: A high `rst` at a rising edge clears the input register and all partial-sum registers, so `y` reads 0 in the cycle after that edge.
- R2: If s(n) is the sample captured at the latest rising edge with `rst` low, then `y` equals A0·s(n) + A1·s(n−1) + A2·s(n−2) + A3·s(n−3) throughout the following cycle. This gives one register of latency from `x` to `y`.
- R3: No overflow: `y` never exceeds (A0+A1+A2+A3)·(2^DW−1). With the defaults, four consecutive samples of 0xF give exactly 375.
- R4: Coefficient order: a single sample of 1 followed by zeros produces 3, 6, 7, 9 and then 0 on `y` in consecutive cycles.
- R5: Samples captured before a reset contribute nothing afterwards. After reset the older taps are treated as zero while the pipeline refills.
- R6: Four consecutive zero samples drive `y` to 0, whatever came before them.
- R7: The repeating hex stream 0,B,1,F,2,D,3,C,4,B,5,A,6,9,7,8 produces the sum in R2 on every cycle, including where the stream wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| x | input | DW (4) | Unsigned input sample |
| y | output | YW (10) | Unsigned filter output, one cycle behind the captured sample |

## Verification
Reset and sample capture can fall in the same cycle. The bench provokes this by raising `rst` while a stream of 0xF samples is still arriving, then releasing it straight into a new sample. The judgement is that `y` is 0 during reset, and that the first outputs afterwards carry only the new samples with none of the pre-reset history (R1, R5). The impulse and all-0xF patterns put the weight order and the maximum sum on `y`. The scoreboard compares every cycle against a direct-form model of the last four samples.

// File: rtl/fir_pkg.sv
`timescale 1ns/1ps
package fir_pkg;
  localparam int TAPS = 4;

  // Width needed to hold the sum of `terms` values each `pw` bits wide.
  function automatic int acc_width(input int pw, input int terms);
    return pw + $clog2(terms);
  endfunction

  // Largest value the full sum can reach with the given weights.
  function automatic int sum_bound(input int dw, input int c0, input int c1,
                                   input int c2, input int c3);
    return (c0 + c1 + c2 + c3) * ((1 << dw) - 1);
  endfunction
endpackage

// File: rtl/fir_tap_mul.sv
`timescale 1ns/1ps
// Constant-weight multiplier built from shifted copies of the sample.
module fir_tap_mul #(
  parameter int DW = 4,
  parameter int CW = 4,
  parameter logic [CW-1:0] COEF = '0
) (
  input  logic [DW-1:0]    x,
  output logic [DW+CW-1:0] prod
);
  localparam int PW = DW + CW;

  logic [PW-1:0] partial [CW+1];
  assign partial[0] = '0;

  for (genvar b = 0; b < CW; b++) begin : g_bit
    if (COEF[b]) begin : g_add
      assign partial[b+1] = partial[b] + (PW'(x) << b);
    end else begin : g_skip
      assign partial[b+1] = partial[b];
    end
  end

  assign prod = partial[CW];
endmodule

// File: rtl/fir_stage.sv
`timescale 1ns/1ps
// One registered adder of the transposed chain. The register holds OW bits;
// the incoming and outgoing sums travel at the common width YW.
module fir_stage #(
  parameter int PW = 8,
  parameter int OW = 8,
  parameter int YW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] prod,
  input  logic [YW-1:0] acc_in,
  output logic [YW-1:0] acc_out
);
  logic [OW-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) acc_q <= '0;
    else     acc_q <= OW'(YW'(prod) + acc_in);
  end

  assign acc_out = YW'(acc_q);
endmodule

// File: rtl/fir4_transposed.sv
`timescale 1ns/1ps
module fir4_transposed #(
  parameter int DW = 4,
  parameter int CW = 4,
  parameter logic [CW-1:0] A0 = 4'd3,
  parameter logic [CW-1:0] A1 = 4'd6,
  parameter logic [CW-1:0] A2 = 4'd7,
  parameter logic [CW-1:0] A3 = 4'd9,
  parameter int YW = DW + CW + $clog2(fir_pkg::TAPS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] x,
  output logic [YW-1:0] y
);
  import fir_pkg::*;

  localparam int PW = DW + CW;
  localparam logic [TAPS-1:0][CW-1:0] COEFS = {A3, A2, A1, A0};

  // Captured sample, shared by all multipliers.
  logic [DW-1:0] x_q;
  always_ff @(posedge clk) begin
    if (rst) x_q <= '0;
    else     x_q <= x;
  end

  logic [PW-1:0] prod [TAPS];
  for (genvar i = 0; i < TAPS; i++) begin : g_mul
    fir_tap_mul #(.DW(DW), .CW(CW), .COEF(COEFS[i])) u_mul (
      .x   (x_q),
      .prod(prod[i])
    );
  end

  // acc_ext[i] carries the partial sum leaving stage i; the far end is zero.
  logic [YW-1:0] acc_ext [TAPS+1];
  assign acc_ext[TAPS] = '0;

  for (genvar i = 1; i < TAPS; i++) begin : g_stage
    localparam int OW = acc_width(PW, TAPS - i);
    fir_stage #(.PW(PW), .OW(OW), .YW(YW)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .prod   (prod[i]),
      .acc_in (acc_ext[i+1]),
      .acc_out(acc_ext[i])
    );
  end

  // Output adder: newest product plus the nearest partial sum.
  assign acc_ext[0] = YW'(prod[0]) + acc_ext[1];
  assign y = acc_ext[0];
endmodule

// File: rtl/fir4_chk.sv
`timescale 1ns/1ps
module fir4_chk #(
  parameter int DW = 4,
  parameter int CW = 4,
  parameter int YW = 10,
  parameter logic [CW-1:0] A0 = 4'd3,
  parameter logic [CW-1:0] A1 = 4'd6,
  parameter logic [CW-1:0] A2 = 4'd7,
  parameter logic [CW-1:0] A3 = 4'd9
) (
  input logic          clk,
  input logic          rst,
  input logic [DW-1:0] x,
  input logic [DW-1:0] x_q,
  input logic [YW-1:0] y
);
  localparam int YMAX = fir_pkg::sum_bound(DW, int'(A0), int'(A1), int'(A2), int'(A3));

  // Direct-form history of captured samples.
  logic [DW-1:0] h [4];
  logic [2:0]    zrun;
  logic [YW-1:0] model_y;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < 4; j++) h[j] <= '0;
      zrun <= '0;
    end else begin
      h[0] <= x;
      for (int j = 1; j < 4; j++) h[j] <= h[j-1];
      if (x != '0)      zrun <= '0;
      else if (zrun < 4) zrun <= zrun + 3'd1;
    end
  end

  always_comb begin
    model_y = YW'(A0) * YW'(h[0]) + YW'(A1) * YW'(h[1])
            + YW'(A2) * YW'(h[2]) + YW'(A3) * YW'(h[3]);
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $fell(rst) |-> (y == '0 && x_q == '0)); // R1
  AST_TAP_SUM:     assert property (@(posedge clk) disable iff (rst) y == model_y); // R2
  AST_INPUT_REG:   assert property (@(posedge clk) disable iff (rst) !$past(rst) |-> x_q == $past(x)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) 32'(y) <= YMAX); // R3
  AST_FLUSH:       assert property (@(posedge clk) disable iff (rst) zrun == 3'd4 |-> y == '0); // R6
endmodule

bind fir4_transposed fir4_chk #(
  .DW(DW), .CW(CW), .YW(YW), .A0(A0), .A1(A1), .A2(A2), .A3(A3)
) u_chk (
  .clk(clk), .rst(rst), .x(x), .x_q(x_q), .y(y)
);

// File: tb/fir4_transposed_tb.sv
`timescale 1ns/1ps
module fir4_transposed_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] x   = 4'd0;
  logic [9:0] y;

  int n_chk  = 0;
  int n_fail = 0;
  int hist [4] = '{0, 0, 0, 0};
  int    exp_q [$];
  string tag_q [$];
  string cur_tag = "R2";
  bit    done = 0;

  localparam int W0 = 3, W1 = 6, W2 = 7, W3 = 9;

  always #2.5 clk = ~clk;

  fir4_transposed u_dut (.clk(clk), .rst(rst), .x(x), .y(y));

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: y actual %0d expected %0d at %0t", req, act, expv, $time);
    end
  endtask

  // Driver: called at a falling edge, applies one sample, queues the result.
  task automatic drive(input int v);
    x = 4'(v);
    for (int j = 3; j > 0; j--) hist[j] = hist[j-1];
    hist[0] = v;
    exp_q.push_back(W0*hist[0] + W1*hist[1] + W2*hist[2] + W3*hist[3]);
    tag_q.push_back(cur_tag);
    @(negedge clk);
  endtask

  // Reset in the middle of a stream: the sample on x is still nonzero.
  task automatic pulse_reset();
    rst = 1'b1;
    x   = 4'hF;
    @(negedge clk);
    @(negedge clk);
    check("R1", int'(y), 0);
    for (int j = 0; j < 4; j++) hist[j] = 0;
    rst = 1'b0;
  endtask

  // Monitor: compares one queued result a little after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), int'(y), exp_q.pop_front());
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int seq [16] = '{'h0, 'hB, 'h1, 'hF, 'h2, 'hD, 'h3, 'hC,
                     'h4, 'hB, 'h5, 'hA, 'h6, 'h9, 'h7, 'h8};
    repeat (3) @(negedge clk);
    check("R1", int'(y), 0);
    rst = 1'b0;

    // R4: impulse gives the weights in order.
    cur_tag = "R4";
    drive(1);
    repeat (4) drive(0);

    // R7: the hex stream, two full passes plus wrap.
    cur_tag = "R7";
    for (int p = 0; p < 2; p++)
      for (int k = 0; k < 16; k++) drive(seq[k]);

    // R3: maximum input held long enough to fill every tap.
    cur_tag = "R3";
    repeat (6) drive(15);
    check("R3", int'(y), 375);

    // R6: zeros flush the pipeline.
    cur_tag = "R6";
    repeat (4) drive(0);
    check("R6", int'(y), 0);

    // R2: alternating extremes.
    cur_tag = "R2";
    for (int k = 0; k < 8; k++) drive((k % 2) ? 15 : 0);

    // R5: reset while samples are arriving; old history must vanish.
    repeat (3) drive(15);
    pulse_reset();
    cur_tag = "R5";
    drive(2);
    drive(0);
    drive(0);
    drive(1);
    drive(0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule